// File: doc/BRIEF.md
# Debounced Level Interrupt Group

This block serves eight input-only external event lines. A two-flop synchroniser samples each pad. A per-channel filter then accepts a new level only after it has held for a programmed number of 1 ms ticks, and the result is kept as that channel's stable level. Software reads the filtered levels through a small word-addressed register port. Each read is qualified by a per-channel read-enable mask.

Interrupts are level-type and single-shot. Software programs a polarity for the channel, enables it, and then writes the channel's bit in the arm register. While the channel is armed, the first cycle in which its stable level matches the polarity sets a latched status bit and disarms the channel. That channel cannot report again until software arms it once more. The single interrupt output is raised while any status bit is set and enabled.

Top module: `dbnc_irq_group`

## Requirements
- R1: After reset every readable register reads 0. Every channel is disarmed and `irq` is low.
- R2: Offset 0x00 returns, in bit n, the stable level of channel n ANDed with bit n of the read-enable register at offset 0x04.
- R3: The filter limit for channel n is held in bits 11:0 of the word at offset 0x40+4n, and the whole written word reads back. A stable level takes a new pad value only after the synchronised pad has differed from it for that many ticks without changing. Any change of the synchronised pad restarts the count. A limit of 0 acts as 1.
- R4: Bit n of the polarity register at offset 0x14 selects the active level of channel n: 1 means high and 0 means low. A channel whose stable level does not match its polarity never sets status.
- R5: Writing 1 to bit n at offset 0x28 arms channel n. An armed channel whose stable level matches its polarity sets its status bit and becomes disarmed. Status then stays unset after a clear until the channel is armed again.
- R6: Writing 1 to bit n at offset 0x24 clears status bit n, and writing 0 leaves it unchanged. The status register at offset 0x1C shows the raw status bits. If a detection and a clear land in the same cycle, the detection wins.
- R7: Offset 0x20 reads the raw status ANDed with the enable register at offset 0x18. `irq` is high exactly when that value is non-zero.
- R8: Writes to the read-only offsets 0x00, 0x1C and 0x20 have no effect. The clear and arm offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| reg_addr | input | 8 | Byte address of the register |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | 8 | Asynchronous pad levels, one per channel |
| irq | output | 1 | Interrupt, high while any enabled status is set |

## Verification
The filter is tested with three kinds of input: steps held long enough, a pulse on one channel shorter than its limit, and a channel programmed with limit 0. Together these separate correct counting from a filter that ignores glitches, never settles, or treats 0 as the maximum. Detection is tested with channels of both polarities whose level already matches when they are armed, and with a channel that starts mismatched and only reports after its pad moves. Clearing is then repeated without re-arming. These cases show that the logic is single-shot and not a plain level follower. A behavioural model compared on every clock checks all register reads and `irq`, whatever address the stimulus leaves selected.

// File: rtl/dbnc_irq_group.sv
module dbnc_irq_group #(
  parameter int CH    = 8,
  parameter int CNT_W = 12,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_ms,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [CH-1:0] pad_in,
  output logic          irq
);
  localparam logic [AW-1:0] A_LVL  = AW'('h00);
  localparam logic [AW-1:0] A_RDEN = AW'('h04);
  localparam logic [AW-1:0] A_POL  = AW'('h14);
  localparam logic [AW-1:0] A_EN   = AW'('h18);
  localparam logic [AW-1:0] A_RAW  = AW'('h1C);
  localparam logic [AW-1:0] A_MSK  = AW'('h20);
  localparam logic [AW-1:0] A_CLR  = AW'('h24);
  localparam logic [AW-1:0] A_ARM  = AW'('h28);
  localparam int            A_CTL  = 'h40;

  logic [CH-1:0] sy1, sy2, sy3;
  logic [CH-1:0] stab_q, rden_q, pol_q, en_q, raw_q, arm_q;
  logic [CH-1:0] hit, clr_m, trg_m;
  logic [DW-1:0] ctl_q [CH];

  assign clr_m = (reg_we && reg_addr == A_CLR) ? reg_wdata[CH-1:0] : '0;
  assign trg_m = (reg_we && reg_addr == A_ARM) ? reg_wdata[CH-1:0] : '0;
  assign hit   = arm_q & ~(stab_q ^ pol_q);
  assign irq   = |(raw_q & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sy1, sy2, sy3} <= '0;
      {rden_q, pol_q, en_q, raw_q, arm_q} <= '0;
    end else begin
      sy1   <= pad_in;
      sy2   <= sy1;
      sy3   <= sy2;
      raw_q <= (raw_q & ~clr_m) | hit;
      arm_q <= (arm_q & ~hit) | trg_m;
      if (reg_we && reg_addr == A_RDEN) rden_q <= reg_wdata[CH-1:0];
      if (reg_we && reg_addr == A_POL)  pol_q  <= reg_wdata[CH-1:0];
      if (reg_we && reg_addr == A_EN)   en_q   <= reg_wdata[CH-1:0];
    end
  end

  for (genvar n = 0; n < CH; n++) begin : g_ch
    localparam logic [AW-1:0] MY_A = AW'(A_CTL + 4 * n);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   lim;
    logic             st;

    assign lim       = (ctl_q[n][CNT_W-1:0] == '0) ? (CNT_W+1)'(1) : {1'b0, ctl_q[n][CNT_W-1:0]};
    assign stab_q[n] = st;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q[n] <= '0;
        cnt      <= '0;
        st       <= 1'b0;
      end else begin
        if (reg_we && reg_addr == MY_A) ctl_q[n] <= reg_wdata;
        if (sy2[n] != sy3[n] || sy2[n] == st) begin
          cnt <= '0;
        end else if (tick_ms) begin
          if ({1'b0, cnt} + 1'b1 >= lim) begin
            st  <= sy2[n];
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_LVL:  reg_rdata[CH-1:0] = stab_q & rden_q;
      A_RDEN: reg_rdata[CH-1:0] = rden_q;
      A_POL:  reg_rdata[CH-1:0] = pol_q;
      A_EN:   reg_rdata[CH-1:0] = en_q;
      A_RAW:  reg_rdata[CH-1:0] = raw_q;
      A_MSK:  reg_rdata[CH-1:0] = raw_q & en_q;
      default: begin
        for (int k = 0; k < CH; k++)
          if (reg_addr == AW'(A_CTL + 4 * k)) reg_rdata = ctl_q[k];
      end
    endcase
  end
endmodule

module dbnc_irq_group_chk #(
  parameter int CH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_ms,
  input logic          irq,
  input logic [CH-1:0] stab_q,
  input logic [CH-1:0] raw_q,
  input logic [CH-1:0] arm_q,
  input logic [CH-1:0] en_q,
  input logic [CH-1:0] hit,
  input logic [CH-1:0] trg_m,
  input logic [CH-1:0] clr_m
);
  // R5
  raw_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(arm_q)) == '0));
  // R5
  hit_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit) & ~$past(trg_m) & arm_q) == '0));
  // R3
  stable_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stab_q == $past(stab_q)) || $past(tick_ms));
  // R6
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(clr_m) & ~$past(hit)) == '0));
  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

bind dbnc_irq_group dbnc_irq_group_chk #(.CH(CH)) chk (.*);

// File: tb/dbnc_irq_group_test.sv
`timescale 1ns/1ps
module dbnc_irq_group_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_ms = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  pad_in = '0;
  logic        irq;

  int errors = 0, checks = 0;
  bit cmp_on = 0;
  int tdiv = 0;

  dbnc_irq_group uut (.clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in), .irq(irq));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    #1;
    tdiv = (tdiv == 9) ? 0 : tdiv + 1;
    tick_ms = (tdiv == 9);
  end

  // behavioural reference
  logic [7:0] m_s1, m_s2, m_s3, m_st, m_rden, m_pol, m_en, m_raw, m_arm;
  logic [7:0] m_hit, m_clr, m_trg;
  int unsigned m_ctl [8];
  int m_cnt [8];

  function automatic logic [31:0] mread(input logic [7:0] a);
    if (a == 8'h00) return {24'h0, m_st & m_rden};
    if (a == 8'h04) return {24'h0, m_rden};
    if (a == 8'h14) return {24'h0, m_pol};
    if (a == 8'h18) return {24'h0, m_en};
    if (a == 8'h1C) return {24'h0, m_raw};
    if (a == 8'h20) return {24'h0, m_raw & m_en};
    if (a >= 8'h40 && a <= 8'h5C && a[1:0] == 2'b00) return m_ctl[(a - 8'h40) / 4];
    return 32'h0;
  endfunction

  function automatic string tagof(input logic [7:0] a);
    if (a == 8'h00 || a == 8'h04) return "R2";
    if (a == 8'h14) return "R4";
    if (a == 8'h18 || a == 8'h20) return "R7";
    if (a == 8'h1C) return "R5";
    if (a >= 8'h40 && a <= 8'h5C) return "R3";
    return "R8";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_s1, m_s2, m_s3, m_st, m_rden, m_pol, m_en, m_raw, m_arm} = '0;
      for (int n = 0; n < 8; n++) begin m_ctl[n] = 0; m_cnt[n] = 0; end
    end else begin
      m_hit = m_arm & ~(m_st ^ m_pol);
      m_clr = (reg_we && reg_addr == 8'h24) ? reg_wdata[7:0] : 8'h0;
      m_trg = (reg_we && reg_addr == 8'h28) ? reg_wdata[7:0] : 8'h0;
      m_raw = (m_raw & ~m_clr) | m_hit;
      m_arm = (m_arm & ~m_hit) | m_trg;
      for (int n = 0; n < 8; n++) begin
        int lim;
        lim = m_ctl[n] % 4096;
        if (lim == 0) lim = 1;
        if (m_s2[n] != m_s3[n] || m_s2[n] == m_st[n]) m_cnt[n] = 0;
        else if (tick_ms) begin
          m_cnt[n] = m_cnt[n] + 1;
          if (m_cnt[n] >= lim) begin m_st[n] = m_s2[n]; m_cnt[n] = 0; end
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pad_in;
      if (reg_we) begin
        if (reg_addr == 8'h04) m_rden = reg_wdata[7:0];
        if (reg_addr == 8'h14) m_pol  = reg_wdata[7:0];
        if (reg_addr == 8'h18) m_en   = reg_wdata[7:0];
        if (reg_addr >= 8'h40 && reg_addr <= 8'h5C && reg_addr[1:0] == 2'b00)
          m_ctl[(reg_addr - 8'h40) / 4] = reg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (irq !== (|(m_raw & m_en))) begin
        errors++;
        $display("FAIL R7 irq actual=%b expected=%b", irq, |(m_raw & m_en));
      end
      checks++;
      if (reg_rdata !== mread(reg_addr)) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", tagof(reg_addr), reg_addr, reg_rdata, mread(reg_addr));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk); #2;
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk); cmp_on = 1;
    // R1 reset state
    rd(8'h00, 0, "R1"); rd(8'h04, 0, "R1"); rd(8'h14, 0, "R1"); rd(8'h18, 0, "R1");
    rd(8'h1C, 0, "R1"); rd(8'h20, 0, "R1"); rd(8'h40, 0, "R1"); chk_irq(1'b0, "R1");
    wr(8'h04, 32'hFF);
    wr(8'h40, 32'hABC0_0003);
    wr(8'h44, 32'h0);
    wr(8'h4C, 32'h2);
    rd(8'h40, 32'hABC0_0003, "R3");
    @(negedge clk); #1 pad_in = 8'h03;
    idle(80);
    rd(8'h00, 32'h03, "R2 R3 settle");
    // R3 short pulse on channel 0 rejected
    @(negedge clk); #1 pad_in = 8'h02;
    idle(15);
    @(negedge clk); #1 pad_in = 8'h03;
    idle(60);
    rd(8'h00, 32'h03, "R3 glitch");
    // R3 limit 0 acts as 1
    @(negedge clk); #1 pad_in = 8'h01;
    idle(30);
    rd(8'h00, 32'h01, "R3 zero limit");
    // R2 read-enable mask
    wr(8'h04, 32'h00);
    rd(8'h00, 32'h00, "R2 masked");
    wr(8'h04, 32'hFF);
    // R5 arm and detect: ch0 high matches pol 1, ch2 low matches pol 0
    wr(8'h14, 32'h01);
    wr(8'h18, 32'h01);
    wr(8'h28, 32'h05);
    idle(3);
    rd(8'h1C, 32'h05, "R5 detect");
    rd(8'h20, 32'h01, "R7 masked");
    chk_irq(1'b1, "R7");
    // R6 clear, R5 no refire while disarmed
    wr(8'h24, 32'h01);
    idle(5);
    rd(8'h1C, 32'h04, "R6 R5 one-shot");
    chk_irq(1'b0, "R7");
    wr(8'h24, 32'h00);
    rd(8'h1C, 32'h04, "R6 zero write");
    // R8 read-only and write-only offsets
    wr(8'h1C, 32'hFF); wr(8'h20, 32'hFF); wr(8'h00, 32'hFF);
    rd(8'h1C, 32'h04, "R8");
    rd(8'h24, 32'h00, "R8"); rd(8'h28, 32'h00, "R8");
    wr(8'h18, 32'h04);
    chk_irq(1'b1, "R7");
    wr(8'h24, 32'h04);
    chk_irq(1'b0, "R7");
    // R5 re-arm
    wr(8'h28, 32'h01);
    idle(3);
    rd(8'h1C, 32'h01, "R5 rearm");
    wr(8'h24, 32'h01);
    // R4 mismatched polarity waits for the pad
    wr(8'h14, 32'h09);
    wr(8'h28, 32'h08);
    idle(10);
    rd(8'h1C, 32'h00, "R4 mismatch");
    @(negedge clk); #1 pad_in = 8'h09;
    idle(60);
    rd(8'h1C, 32'h08, "R4 match");
    idle(20);
    cmp_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule